// File: doc/BRIEF.md
# Externally Clocked Serial Word Receiver

This block takes in serial data whose bit clock comes from an external master. The clock and data lines first pass through a two-stage synchronizer. On each rising edge of the synchronized clock, one data bit is shifted in, least significant bit first. A word is 8 bits long, or 9 bits long when the nine-bit mode input is high.

When a word is complete, it moves into a two-entry receive buffer. A ready flag shows that the buffer holds data. An interrupt request follows the ready flag, gated by an interrupt enable. The head entry appears on the read data outputs, with the ninth bit on its own status output. A read strobe removes the head entry.

A word that completes while the buffer is full is dropped, and an overrun flag sets. Once the flag is set, no further words enter the buffer. The flag stays set until the continuous-receive enable is dropped. Dropping that enable also discards any partly shifted word.

Reception does not depend on the core's low-power state. While the core sleeps, an active interrupt request also drives a wake request. A single-shot receive input, which has meaning only for a clock-generating master, is accepted and ignored.

Top module: `sync_slave_rx`

## Requirements
- R1: Bits are shifted in only while `port_en` and `cont_rx_en` are both high. While either is low, the bit count and any partly received word are cleared, so the next word starts at bit 0.
- R2: `single_rx_en` has no effect on any output.
- R3: Bits are sampled on rising edges of `ser_clk`, least significant bit first. The completed word enters the buffer, and `rx_ready` rises after the 4th clock edge that follows the `ser_clk` rise carrying the final bit. `rd_data` then shows the word.
- R4: `irq` is high exactly when `rx_ready` and `rx_irq_en` are both high.
- R5: With `nine_bit_mode` high, a word is 9 bits long. Bits 0 to 7 go to `rd_data` and bit 8 goes to `rd_bit9`. With it low, a word is 8 bits long and `rd_bit9` reads 0.
- R6: A word that completes while the buffer holds 2 entries, with no read in the same cycle, is discarded and sets `overrun`. While `overrun` is high, completed words are discarded. `overrun` clears only on the clock after `cont_rx_en` is low.
- R7: Reception works the same whatever the value of `core_sleep`. `wake` is high exactly when `core_sleep` and `irq` are both high.
- R8: The buffer holds 2 words in arrival order. `rd_strobe` removes the head entry on the next clock edge when the buffer is not empty. `rx_ready` stays high until the last entry is removed.
- R9: After reset, `rx_ready`, `overrun`, `irq` and `wake` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_clk | input | 1 | External serial bit clock |
| ser_dat | input | 1 | Serial data line |
| port_en | input | 1 | Serial port enable |
| cont_rx_en | input | 1 | Continuous receive enable; low clears overrun |
| single_rx_en | input | 1 | Single-shot receive enable, ignored in this mode |
| nine_bit_mode | input | 1 | High selects 9-bit words |
| rx_irq_en | input | 1 | Receive interrupt enable |
| core_sleep | input | 1 | Core is in a low-power state |
| rd_strobe | input | 1 | Remove the head buffer entry |
| rd_data | output | 8 | Low 8 bits of the head entry |
| rd_bit9 | output | 1 | Ninth bit of the head entry |
| rx_ready | output | 1 | Buffer is not empty |
| overrun | output | 1 | A word was lost to a full buffer |
| irq | output | 1 | Receive interrupt request |
| wake | output | 1 | Wake request while sleeping |

## Verification
A `ser_clk` rise takes two clock edges to pass the synchronizer and one more to be shifted in. The buffer write lands on the 4th edge, so `rx_ready`, `rd_data` and `rd_bit9` change after that edge. `irq` and `wake` follow in the same cycle, because they are combinational from the ready flag, the enables and `core_sleep`. A read strobe or a change of `cont_rx_en` takes effect on the next edge. The bench's reference model advances once per clock edge on the inputs sampled at that edge, and the outputs are compared a short delay after every edge. Directed checks are made once each transfer has had six or more edges to settle.

// File: rtl/sync_rx_pkg.sv
package sync_rx_pkg;
   localparam int DEF_DATA_W = 8;
   localparam int DEF_DEPTH  = 2;
   localparam int DEF_SYNC   = 2;

   function automatic bit is_pow2(input int n);
      return (n > 0) && ((n & (n - 1)) == 0);
   endfunction
endpackage

// File: rtl/sync_rx_sync.sv
module sync_rx_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   if (STAGES < 2) begin : g_bad
      $error("sync_rx_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[0] <= '0;
            else        stage_q[0] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/sync_rx_shifter.sv
module sync_rx_shifter #(
   parameter int DATA_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            active,
   input  logic            nine_bit,
   input  logic            bclk,
   input  logic            bdat,
   output logic            word_done,
   output logic [DATA_W:0] word
);
   localparam int MAX_BITS = DATA_W + 1;
   localparam int CNT_W    = $clog2(MAX_BITS + 1);
   localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(DATA_W);
   localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(DATA_W - 1);

   if (DATA_W < 2) begin : g_bad
      $error("sync_rx_shifter: DATA_W must be at least 2");
   end

   logic             bclk_prev;
   logic             rise;
   logic [CNT_W-1:0] cnt_q;
   logic [DATA_W:0]  acc_q;
   logic [DATA_W:0]  acc_nxt;
   logic             last_bit;

   assign rise     = bclk & ~bclk_prev;
   assign last_bit = (cnt_q == (nine_bit ? LAST_LONG : LAST_SHORT));

   always_comb begin
      acc_nxt        = acc_q;
      acc_nxt[cnt_q] = bdat;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bclk_prev <= 1'b0;
      else        bclk_prev <= bclk;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         acc_q     <= '0;
         word_done <= 1'b0;
         word      <= '0;
      end else begin
         word_done <= 1'b0;
         if (!active) begin
            cnt_q <= '0;
            acc_q <= '0;
         end else if (rise) begin
            if (last_bit) begin
               word_done <= 1'b1;
               word      <= acc_nxt;
               cnt_q     <= '0;
               acc_q     <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
               acc_q <= acc_nxt;
            end
         end
      end
   end
endmodule

// File: rtl/sync_rx_buffer.sv
module sync_rx_buffer #(
   parameter int WORD_W = 9,
   parameter int DEPTH  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [WORD_W-1:0] push_word,
   input  logic              pop_req,
   input  logic              ovr_clear,
   output logic [WORD_W-1:0] head,
   output logic              not_empty,
   output logic              ovr
);
   localparam int PTR_W = $clog2(DEPTH);
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

   if (!sync_rx_pkg::is_pow2(DEPTH) || DEPTH < 2) begin : g_bad
      $error("sync_rx_buffer: DEPTH must be a power of two, at least 2");
   end

   logic [WORD_W-1:0] mem_q [DEPTH];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr;
   logic [CNT_W-1:0]  count;
   logic              pop, full, wr_en, ovr_set;

   assign full    = (count == FULL_CNT);
   assign pop     = pop_req && (count != '0);
   assign wr_en   = push && !ovr && (!full || pop);
   assign ovr_set = push && !ovr && full && !pop;

   always_ff @(posedge clk) begin
      if (wr_en) mem_q[wr_ptr] <= push_word;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
         ovr    <= 1'b0;
      end else begin
         if (wr_en) wr_ptr <= wr_ptr + 1'b1;
         if (pop)   rd_ptr <= rd_ptr + 1'b1;
         case ({wr_en, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
         if (ovr_clear)    ovr <= 1'b0;
         else if (ovr_set) ovr <= 1'b1;
      end
   end

   assign head      = mem_q[rd_ptr];
   assign not_empty = (count != '0);
endmodule

// File: rtl/sync_slave_rx.sv
module sync_slave_rx #(
   parameter int DATA_W = sync_rx_pkg::DEF_DATA_W,
   parameter int DEPTH  = sync_rx_pkg::DEF_DEPTH,
   parameter int SYNC   = sync_rx_pkg::DEF_SYNC
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_clk,
   input  logic              ser_dat,
   input  logic              port_en,
   input  logic              cont_rx_en,
   input  logic              single_rx_en,
   input  logic              nine_bit_mode,
   input  logic              rx_irq_en,
   input  logic              core_sleep,
   input  logic              rd_strobe,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_bit9,
   output logic              rx_ready,
   output logic              overrun,
   output logic              irq,
   output logic              wake
);
   localparam int WORD_W = DATA_W + 1;

   logic [1:0]        line_sync;
   logic              active;
   logic              word_done;
   logic [WORD_W-1:0] word;
   logic [WORD_W-1:0] head;
   logic              unused_single;

   assign unused_single = single_rx_en;
   assign active        = port_en & cont_rx_en;

   sync_rx_sync #(.WIDTH(2), .STAGES(SYNC)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  ({ser_clk, ser_dat}),
      .dout (line_sync)
   );

   sync_rx_shifter #(.DATA_W(DATA_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .active   (active),
      .nine_bit (nine_bit_mode),
      .bclk     (line_sync[1]),
      .bdat     (line_sync[0]),
      .word_done(word_done),
      .word     (word)
   );

   sync_rx_buffer #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_buf (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (word_done),
      .push_word(word),
      .pop_req  (rd_strobe),
      .ovr_clear(!cont_rx_en),
      .head     (head),
      .not_empty(rx_ready),
      .ovr      (overrun)
   );

   assign rd_data = head[DATA_W-1:0];
   assign rd_bit9 = head[DATA_W];
   assign irq     = rx_ready & rx_irq_en;
   assign wake    = irq & core_sleep;
endmodule

// File: rtl/sync_rx_checker.sv
module sync_rx_checker (
   input logic clk,
   input logic rst_n,
   input logic port_en,
   input logic cont_rx_en,
   input logic core_sleep,
   input logic word_done,
   input logic rx_ready,
   input logic overrun,
   input logic irq,
   input logic wake
);
   AST_IDLE_NO_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      !(port_en && cont_rx_en) |=> !word_done); // R1
   AST_WORD_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (word_done && !overrun) |=> rx_ready); // R3
   AST_OVR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (overrun && cont_rx_en) |=> overrun); // R6
   AST_OVR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      !cont_rx_en |=> !overrun); // R6
   AST_WAKE_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
      wake |-> (core_sleep && irq)); // R7
   AST_IRQ_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> rx_ready); // R4
endmodule

bind sync_slave_rx sync_rx_checker u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .port_en   (port_en),
   .cont_rx_en(cont_rx_en),
   .core_sleep(core_sleep),
   .word_done (word_done),
   .rx_ready  (rx_ready),
   .overrun   (overrun),
   .irq       (irq),
   .wake      (wake)
);

// File: tb/sync_slave_rx_test.sv
`timescale 1ns/1ps
module sync_slave_rx_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ser_clk = 1'b0, ser_dat = 1'b0;
   logic port_en = 1'b0, cont_rx_en = 1'b0, single_rx_en = 1'b0;
   logic nine_bit_mode = 1'b0, rx_irq_en = 1'b0, core_sleep = 1'b0;
   logic rd_strobe = 1'b0;
   logic [7:0] rd_data;
   logic rd_bit9, rx_ready, overrun, irq, wake;

   int total = 0;
   int bad = 0;
   int cycles = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   sync_slave_rx uut (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
      .port_en(port_en), .cont_rx_en(cont_rx_en), .single_rx_en(single_rx_en),
      .nine_bit_mode(nine_bit_mode), .rx_irq_en(rx_irq_en),
      .core_sleep(core_sleep), .rd_strobe(rd_strobe), .rd_data(rd_data),
      .rd_bit9(rd_bit9), .rx_ready(rx_ready), .overrun(overrun), .irq(irq),
      .wake(wake)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // reference model
   int  m_q[$];
   bit  m_c1, m_c2, m_cp, m_d1, m_d2;
   int  m_cnt, m_acc, m_word;
   bit  m_pend, m_ovr;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_q.delete();
         {m_c1, m_c2, m_cp, m_d1, m_d2, m_pend, m_ovr} = '0;
         m_cnt = 0; m_acc = 0; m_word = 0;
      end else begin
         int  osz;
         bit  pop, ovr_n, pend_n, rise;
         osz   = m_q.size();
         pop   = rd_strobe && (osz > 0);
         if (pop) void'(m_q.pop_front());
         ovr_n = m_ovr;
         if (m_pend && !m_ovr) begin
            if (osz == 2 && !pop) ovr_n = 1'b1;
            else m_q.push_back(m_word);
         end
         if (!cont_rx_en) ovr_n = 1'b0;
         m_ovr  = ovr_n;
         pend_n = 1'b0;
         rise   = m_c2 && !m_cp;
         if (!(port_en && cont_rx_en)) begin
            m_cnt = 0; m_acc = 0;
         end else if (rise) begin
            m_acc = m_acc | (int'(m_d2) << m_cnt);
            if (m_cnt == (nine_bit_mode ? 8 : 7)) begin
               pend_n = 1'b1; m_word = m_acc; m_cnt = 0; m_acc = 0;
            end else m_cnt++;
         end
         m_pend = pend_n;
         m_cp = m_c2; m_c2 = m_c1; m_c1 = ser_clk;
         m_d2 = m_d1; m_d1 = ser_dat;
      end
      #2;
      if (rst_n && !done) begin
         bit exp_rdy;
         exp_rdy = (m_q.size() > 0);
         check("R8", "rx_ready", int'(rx_ready), int'(exp_rdy));
         check("R6", "overrun", int'(overrun), int'(m_ovr));
         check("R4", "irq", int'(irq), int'(exp_rdy && rx_irq_en));
         check("R7", "wake", int'(wake), int'(exp_rdy && rx_irq_en && core_sleep));
         if (exp_rdy) begin
            check("R3", "rd_data", int'(rd_data), m_q[0] & 8'hFF);
            check("R5", "rd_bit9", int'(rd_bit9), (m_q[0] >> 8) & 1);
         end
      end
   end

   task automatic send(input int val, input int nbits, input bit toggle_single = 1'b0);
      for (int i = 0; i < nbits; i++) begin
         @(negedge clk);
         ser_dat = val[i];
         if (toggle_single) single_rx_en = ~single_rx_en;
         repeat (3) @(negedge clk);
         ser_clk = 1'b1;
         repeat (3) @(negedge clk);
         ser_clk = 1'b0;
      end
      repeat (6) @(negedge clk);
      #1;
   endtask

   task automatic read_one();
      @(negedge clk);
      rd_strobe = 1'b1;
      @(negedge clk);
      rd_strobe = 1'b0;
      #1;
   endtask

   initial begin
      while (!done && cycles < 200000) begin
         @(posedge clk);
         cycles++;
      end
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog: actual=%0d expected<200000", cycles);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      check("R9", "rx_ready reset", int'(rx_ready), 0);
      check("R9", "overrun reset", int'(overrun), 0);
      check("R9", "irq reset", int'(irq), 0);
      check("R9", "wake reset", int'(wake), 0);
      @(negedge clk);
      rst_n = 1'b1;
      port_en = 1'b1; cont_rx_en = 1'b1;

      send(8'hA5, 8);
      check("R3", "lsb-first data", int'(rd_data), 8'hA5);
      check("R4", "irq disabled", int'(irq), 0);
      check("R5", "bit9 in 8-bit mode", int'(rd_bit9), 0);
      rx_irq_en = 1'b1;
      #1;
      check("R4", "irq enabled", int'(irq), 1);
      read_one();
      check("R8", "empty after last read", int'(rx_ready), 0);

      nine_bit_mode = 1'b1;
      send(9'h1C3, 9);
      check("R5", "low bits 9-bit", int'(rd_data), 8'hC3);
      check("R5", "ninth bit", int'(rd_bit9), 1);
      read_one();
      nine_bit_mode = 1'b0;

      send(8'h11, 8);
      send(8'h22, 8);
      read_one();
      check("R8", "ready with one left", int'(rx_ready), 1);
      check("R8", "arrival order", int'(rd_data), 8'h22);
      read_one();

      send(8'h31, 8);
      send(8'h32, 8);
      send(8'h33, 8);
      check("R6", "overrun set", int'(overrun), 1);
      check("R6", "head kept", int'(rd_data), 8'h31);
      read_one();
      read_one();
      send(8'h44, 8);
      check("R6", "blocked while overrun", int'(rx_ready), 0);
      @(negedge clk);
      cont_rx_en = 1'b0;
      @(negedge clk);
      #1;
      check("R6", "overrun cleared", int'(overrun), 0);
      cont_rx_en = 1'b1;

      port_en = 1'b0;
      send(8'h66, 8);
      check("R1", "no rx with port off", int'(rx_ready), 0);
      port_en = 1'b1;
      send(4'hF, 4);
      @(negedge clk);
      cont_rx_en = 1'b0;
      repeat (2) @(negedge clk);
      cont_rx_en = 1'b1;
      send(8'h5A, 8);
      check("R1", "partial word discarded", int'(rd_data), 8'h5A);
      read_one();

      send(8'h96, 8, 1'b1);
      check("R2", "single enable ignored", int'(rd_data), 8'h96);
      read_one();

      core_sleep = 1'b1;
      send(8'h3C, 8);
      check("R7", "rx while asleep", int'(rd_data), 8'h3C);
      check("R7", "wake raised", int'(wake), 1);
      rx_irq_en = 1'b0;
      #1;
      check("R7", "wake needs irq", int'(wake), 0);
      read_one();
      core_sleep = 1'b0;

      repeat (4) @(negedge clk);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule